// File: doc/BRIEF.md
# Twin Down-Counter Timer with Watchdog and Interrupt Flags

This unit provides two general-purpose down-counters and one watchdog down-counter. Each counter has a current-count register and a reload register. A single control word holds one enable bit and one auto-reload bit for each counter. When an enabled counter sits at zero, it raises an expiry event. The event sets a sticky flag in an interrupt-flag register. Software clears a flag by writing a zero to its bit; a one written to a bit leaves that flag as it is. A mask register chooses which flags drive the single interrupt line.

With auto-reload on, an expired counter copies its reload value and keeps counting, so it produces periodic ticks. With auto-reload off, it runs once and then stays at zero. If the count and the reload value are both all ones and auto-reload is on, the counter acts as a free-running timebase.

Each counter has its own small state machine with three states. CNT_OFF means the enable bit is clear. CNT_RUN means the counter is counting. CNT_SPENT means a one-shot run has expired. The transitions are:
- OFF→RUN when the enable bit is set, or OFF→SPENT if a one-shot expiry happens in that same first cycle.
- RUN→OFF when the enable bit is cleared.
- RUN→SPENT on an expiry with auto-reload off.
- SPENT→RUN when the count register is written while the counter is enabled.
- SPENT→OFF when the enable bit is cleared.

Top module: `tmr_unit`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: Control word (word 0): counter n (0, 1 for the general timers, 2 for the watchdog) is enabled by bit 2n and has auto-reload by bit 2n+1. So the watchdog uses bits 4 and 5. Bits 31:6 read back as zero.
- R3: An enabled, running counter drops by exactly one per clock. A disabled counter holds its value.
- R4: A write to a count register loads the written value at that clock edge. It overrides any decrement or expiry in the same cycle. Reading the count register returns the live count.
- R5: An enabled, running counter at zero expires. The expiry sets flag bit n+1 (bit 1 for timer 0, bit 2 for timer 1, bit 3 for the watchdog), whatever the mask says.
- R6: On an expiry with auto-reload on, the count takes the reload value and counting continues. The period is reload+1 clocks.
- R7: On an expiry with auto-reload off, the count stays at zero and no further expiry occurs until the count register is written again.
- R8: A write to the flag register (word 7) clears each flag whose written bit is 0 and keeps each flag whose written bit is 1. Bit 0 and bits 31:4 always read zero.
- R9: If an expiry and a clearing write hit the same flag in the same cycle, the flag stays set.
- R10: The mask register (word 8) has enable bits at positions 3:1, and all other bits read zero. `irq_o` is high exactly when some flag and its mask bit are both set.
- R11: With count and reload both all ones and auto-reload on, the elapsed clocks since the start equal all ones minus the value read back.
- R12: Word map: 0 control, 1 timer-0 count, 2 timer-0 reload, 3 timer-1 count, 4 timer-1 reload, 5 watchdog count, 6 watchdog reload, 7 flags, 8 mask. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; counters step on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 4 | Word address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational from the registers |
| irq_o | output | 1 | Interrupt line: OR of flags ANDed with the mask |

## Verification
The bound checker watches every cycle for several relations:
- single-step decrement while running, and hold while disabled;
- load on a count write;
- the flag set that follows each expiry, which also covers the expiry-beats-clear case;
- the reload copy on a periodic expiry;
- the one-shot rest at zero;
- clearing by a written zero;
- the interrupt staying low while the mask is empty or no flag is set.

Only the bench scenarios can show the rest: the exact word and bit layout seen through readback, the reload period measured in clocks, the elapsed-tick reading of the free-running counter, and which individual flags survive a partial clear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        CNT_OFF   = 2'd0,
        CNT_RUN   = 2'd1,
        CNT_SPENT = 2'd2
    } cnt_state_e;

    // word offset of the count register of counter idx
    function automatic int unsigned val_offset(int unsigned idx);
        return 1 + 2 * idx;
    endfunction

    // word offset of the reload register of counter idx
    function automatic int unsigned rld_offset(int unsigned idx);
        return 2 + 2 * idx;
    endfunction

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          reload_en,
    input  logic          val_wr,
    input  logic          rld_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cnt_o,
    output logic [DW-1:0] rld_o,
    output logic          expire_o,
    output logic          active_o
);

    cnt_state_e    state_q, state_d;
    logic [DW-1:0] cnt_q;
    logic [DW-1:0] rld_q;
    logic          active;
    logic          expire;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CNT_OFF;
        else        state_q <= state_d;
    end

    // outputs of the state machine
    always_comb begin
        active = en && (state_q != CNT_SPENT);
        expire = active && !val_wr && (cnt_q == '0);
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_OFF: begin
                if (en) state_d = (expire && !reload_en) ? CNT_SPENT : CNT_RUN;
            end
            CNT_RUN: begin
                if (!en)                       state_d = CNT_OFF;
                else if (expire && !reload_en) state_d = CNT_SPENT;
            end
            CNT_SPENT: begin
                if (!en)         state_d = CNT_OFF;
                else if (val_wr) state_d = CNT_RUN;
            end
            default: state_d = CNT_OFF;
        endcase
    end

    // count datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (val_wr) begin
            cnt_q <= wdata;
        end else if (expire) begin
            if (reload_en) cnt_q <= rld_q;
        end else if (active) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rld_q <= '0;
        else if (rld_wr) rld_q <= wdata;
    end

    assign cnt_o    = cnt_q;
    assign rld_o    = rld_q;
    assign expire_o = expire;
    assign active_o = active;

endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
    parameter int NT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] exp_vec,
    input  logic          cause_wr,
    input  logic          mask_wr,
    input  logic [NT-1:0] wbits,
    output logic [NT-1:0] cause_o,
    output logic [NT-1:0] mask_o,
    output logic          irq_o
);

    logic [NT-1:0] cause_q;
    logic [NT-1:0] mask_q;

    generate
        for (genvar i = 0; i < NT; i++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                    cause_q[i] <= 1'b0;
                else if (exp_vec[i])           cause_q[i] <= 1'b1;
                else if (cause_wr && !wbits[i]) cause_q[i] <= 1'b0;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= wbits;
    end

    assign cause_o = cause_q;
    assign mask_o  = mask_q;
    assign irq_o   = |(cause_q & mask_q);

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_GP = 2,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_o
);

    localparam int NUM_TMR    = NUM_GP + 1;
    localparam int CTRL_W     = 2 * NUM_TMR;
    localparam int CAUSE_ADDR = 1 + 2 * NUM_TMR;
    localparam int MASK_ADDR  = CAUSE_ADDR + 1;

    logic [CTRL_W-1:0]                ctrl_q;
    logic [NUM_TMR-1:0][DATA_W-1:0]   cnt_arr;
    logic [NUM_TMR-1:0][DATA_W-1:0]   rld_arr;
    logic [NUM_TMR-1:0]               exp_vec;
    logic [NUM_TMR-1:0]               act_vec;
    logic [NUM_TMR-1:0]               val_wr;
    logic [NUM_TMR-1:0]               rld_wr;
    logic [NUM_TMR-1:0]               cause_q;
    logic [NUM_TMR-1:0]               mask_q;
    logic                             ctrl_wr;
    logic                             cause_wr;
    logic                             mask_wr;

    assign ctrl_wr  = wr_en && (addr == '0);
    assign cause_wr = wr_en && (addr == ADDR_W'(CAUSE_ADDR));
    assign mask_wr  = wr_en && (addr == ADDR_W'(MASK_ADDR));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= wdata[CTRL_W-1:0];
    end

    generate
        for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
            assign val_wr[i] = wr_en && (addr == ADDR_W'(val_offset(i)));
            assign rld_wr[i] = wr_en && (addr == ADDR_W'(rld_offset(i)));

            tmr_counter #(.DW(DATA_W)) u_cnt (
                .clk       (clk),
                .rst_n     (rst_n),
                .en        (ctrl_q[2*i]),
                .reload_en (ctrl_q[2*i+1]),
                .val_wr    (val_wr[i]),
                .rld_wr    (rld_wr[i]),
                .wdata     (wdata),
                .cnt_o     (cnt_arr[i]),
                .rld_o     (rld_arr[i]),
                .expire_o  (exp_vec[i]),
                .active_o  (act_vec[i])
            );
        end
    endgenerate

    tmr_flags #(.NT(NUM_TMR)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .exp_vec  (exp_vec),
        .cause_wr (cause_wr),
        .mask_wr  (mask_wr),
        .wbits    (wdata[NUM_TMR:1]),
        .cause_o  (cause_q),
        .mask_o   (mask_q),
        .irq_o    (irq_o)
    );

    // register readback
    always_comb begin
        rdata = '0;
        if (addr == '0) rdata = DATA_W'(ctrl_q);
        if (addr == ADDR_W'(CAUSE_ADDR)) rdata = DATA_W'({cause_q, 1'b0});
        if (addr == ADDR_W'(MASK_ADDR))  rdata = DATA_W'({mask_q, 1'b0});
        for (int i = 0; i < NUM_TMR; i++) begin
            if (addr == ADDR_W'(val_offset(i))) rdata = cnt_arr[i];
            if (addr == ADDR_W'(rld_offset(i))) rdata = rld_arr[i];
        end
    end

endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
    parameter int DW = 32,
    parameter int NT = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cause_wr,
    input logic [DW-1:0]         wdata,
    input logic                  irq,
    input logic [2*NT-1:0]       ctrl_q,
    input logic [NT-1:0]         cause_q,
    input logic [NT-1:0]         mask_q,
    input logic [NT-1:0][DW-1:0] cnt,
    input logic [NT-1:0][DW-1:0] rld,
    input logic [NT-1:0]         exp_vec,
    input logic [NT-1:0]         run_vec,
    input logic [NT-1:0]         vwr
);

    generate
        for (genvar i = 0; i < NT; i++) begin : g_chk
            p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
                run_vec[i] && !vwr[i] && (cnt[i] != '0) |=> cnt[i] == $past(cnt[i]) - 1'b1);

            p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
                !ctrl_q[2*i] && !vwr[i] |=> $stable(cnt[i]));

            p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
                vwr[i] |=> cnt[i] == $past(wdata));

            p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
                exp_vec[i] |=> cause_q[i]);

            p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
                exp_vec[i] && ctrl_q[2*i+1] |=> cnt[i] == $past(rld[i]));

            p_oneshot_rest_r7: assert property (@(posedge clk) disable iff (!rst_n)
                exp_vec[i] && !ctrl_q[2*i+1] |=> !exp_vec[i] && (cnt[i] == '0));

            p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
                cause_wr && !wdata[i+1] && !exp_vec[i] |=> !cause_q[i]);
        end
    endgenerate

    p_irq_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

    p_irq_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cause_q != '0));

endmodule

bind tmr_unit tmr_unit_chk #(.DW(DATA_W), .NT(NUM_TMR)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cause_wr (cause_wr),
    .wdata    (wdata),
    .irq      (irq_o),
    .ctrl_q   (ctrl_q),
    .cause_q  (cause_q),
    .mask_q   (mask_q),
    .cnt      (cnt_arr),
    .rld      (rld_arr),
    .exp_vec  (exp_vec),
    .run_vec  (act_vec),
    .vwr      (val_wr)
);

// File: tb/tmr_unit_test.sv
module tmr_unit_test;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic        wr_en;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq_o;

    int checks;
    int fails;
    bit finished;

    // scoreboard queues
    logic [31:0] q_data[$];
    logic        q_irq[$];
    logic [3:0]  q_addr[$];
    string       q_tag[$];

    tmr_unit uut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq_o (irq_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // monitor: pops one expected item per falling edge
    always @(negedge clk) begin
        if (q_data.size() > 0) begin
            logic [31:0] ed;
            logic        ei;
            logic [3:0]  ea;
            string       tg;
            ed = q_data.pop_front();
            ei = q_irq.pop_front();
            ea = q_addr.pop_front();
            tg = q_tag.pop_front();
            checks++;
            if (rdata !== ed) begin
                fails++;
                $display("FAIL %s: word %0d read %h expected %h", tg, ea, rdata, ed);
            end
            checks++;
            if (irq_o !== ei) begin
                fails++;
                $display("FAIL %s: irq_o %b expected %b", tg, irq_o, ei);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] d, input logic i, input string tag);
        addr = a;
        q_data.push_back(d);
        q_irq.push_back(i);
        q_addr.push_back(a);
        q_tag.push_back(tag);
        @(negedge clk); #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, got hang expected completion");
        summary();
    end

    initial begin
        checks = 0; fails = 0; finished = 1'b0;
        rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 / R12: everything reads zero after reset
        for (int a = 0; a < 10; a++) rd(4'(a), 32'h0, 1'b0, "R1 reset value");

        // R2: control layout, upper bits dropped
        wr(4'd0, 32'hFFFF_FFEA);
        rd(4'd0, 32'h0000_002A, 1'b0, "R2 control readback");
        wr(4'd0, 32'h0);

        // R12: reload registers at their own words
        wr(4'd2, 32'h11); wr(4'd4, 32'h22); wr(4'd6, 32'h33);
        rd(4'd2, 32'h11, 1'b0, "R12 timer0 reload word");
        rd(4'd4, 32'h22, 1'b0, "R12 timer1 reload word");
        rd(4'd6, 32'h33, 1'b0, "R12 watchdog reload word");

        // R4 load while disabled, R3 hold while disabled
        wr(4'd1, 32'd100);
        rd(4'd1, 32'd100, 1'b0, "R4 count load");
        idle(5);
        rd(4'd1, 32'd100, 1'b0, "R3 hold while disabled");

        // R3 decrement: enable timer0 (bit 0)
        wr(4'd0, 32'h1);
        idle(10);
        rd(4'd1, 32'd90, 1'b0, "R3 one step per clock");
        // R4 override while running, then stop
        wr(4'd1, 32'd50);
        rd(4'd1, 32'd50, 1'b0, "R4 write overrides decrement");
        wr(4'd0, 32'h0);
        rd(4'd1, 32'd48, 1'b0, "R3 count then hold after disable");

        // R5 / R7: timer1 one-shot, mask empty
        wr(4'd3, 32'd3);
        wr(4'd0, 32'h4);
        idle(6);
        rd(4'd7, 32'h4, 1'b0, "R5 timer1 flag at bit 2, masked off");
        rd(4'd3, 32'h0, 1'b0, "R7 one-shot rests at zero");
        wr(4'd7, 32'hFFFF_FFFB);
        rd(4'd7, 32'h0, 1'b0, "R8 clear by written zero");
        idle(10);
        rd(4'd7, 32'h0, 1'b0, "R7 no repeat expiry");
        wr(4'd0, 32'h0);

        // R8 partial clear with two flags set
        wr(4'd1, 32'd2); wr(4'd3, 32'd2);
        wr(4'd0, 32'h5);
        idle(6);
        rd(4'd7, 32'h6, 1'b0, "R5 timer0 bit 1 and timer1 bit 2");
        wr(4'd7, 32'hFFFF_FFFD);
        rd(4'd7, 32'h4, 1'b0, "R8 ones keep, zero clears");
        wr(4'd7, 32'h0);
        rd(4'd7, 32'h0, 1'b0, "R8 all cleared");
        wr(4'd0, 32'h0);

        // R10: mask and interrupt via the watchdog
        wr(4'd8, 32'hFFFF_FFFF);
        rd(4'd8, 32'hE, 1'b0, "R10 mask bits 3:1 only");
        wr(4'd5, 32'd1);
        wr(4'd0, 32'h10);
        idle(4);
        rd(4'd7, 32'h8, 1'b1, "R5 watchdog bit 3, R10 irq high");
        wr(4'd8, 32'h6);
        rd(4'd8, 32'h6, 1'b0, "R10 irq low when masked");
        wr(4'd8, 32'h8);
        rd(4'd8, 32'h8, 1'b1, "R10 irq high when unmasked");
        wr(4'd7, 32'h0);
        rd(4'd7, 32'h0, 1'b0, "R10 irq drops after clear");
        wr(4'd0, 32'h0);
        wr(4'd8, 32'h0);

        // R6 periodic timer0 and R9 same-cycle clear vs expiry
        wr(4'd2, 32'd4); wr(4'd1, 32'd4);
        wr(4'd0, 32'h3);
        idle(7);
        rd(4'd1, 32'd2, 1'b0, "R6 reload after expiry");
        rd(4'd7, 32'h2, 1'b0, "R5 periodic flag bit 1");
        wr(4'd7, 32'h0);
        rd(4'd7, 32'h2, 1'b0, "R9 expiry wins over clear");
        rd(4'd1, 32'd3, 1'b0, "R6 period of reload+1");
        wr(4'd0, 32'h0);
        wr(4'd7, 32'h0);
        rd(4'd7, 32'h0, 1'b0, "R8 cleared after stop");

        // R11 free-running timer1
        wr(4'd4, 32'hFFFF_FFFF); wr(4'd3, 32'hFFFF_FFFF);
        wr(4'd0, 32'hC);
        idle(20);
        rd(4'd3, 32'hFFFF_FFFF - 32'd20, 1'b0, "R11 elapsed 20 ticks");
        wr(4'd0, 32'h0);

        idle(2);
        summary();
    end

endmodule